// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This unit sits beside a UART whose receive queue holds 64 characters. It handles hardware handshaking in both directions. On the receive side it raises the RTS line when the receive queue fills to a programmable halt level. It drops RTS again only once the queue has drained to a lower resume level, so the line does not chatter. On the transmit side it passes the incoming CTS line through a synchronizer. It then produces a stop request for the transmitter, and that request changes only while the transmitter is between characters.

It also compares each received character with a programmable match character. A hit sets a sticky interrupt-status flag. The character itself is still forwarded to the receive queue's write port. The flag clears when the host reads the interrupt-identification register.

The unit also owns the small register set that these features depend on. Writes to the extended fields of the interrupt-enable, FIFO-control and modem-control registers are honoured only while the enhanced-functions bit is set. Writes to the divisor bytes are dropped while sleep is enabled.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, every register output, `rts_out`, `tx_stop`, `spchar_flag` and `fifo_we` read 0.
- R2: With control bit 7 set, a HIGH on `cts_in` sets `tx_stop` on the third rising edge after it is applied, provided `tx_idle` is high. With control bit 7 clear, `cts_in` has no effect and `tx_stop` falls or stays 0.
- R3: `tx_stop` changes value only on an edge where `tx_idle` was high, so a character in flight is always finished.
- R4: With control bit 6 set, `rts_out` goes HIGH one cycle after `rx_level` reaches 4 × trigger[3:0] (the halt level).
- R5: Once HIGH, `rts_out` stays HIGH while `rx_level` is above 4 × trigger[7:4] (the resume level). It goes LOW one cycle after the level falls to the resume level or below, and it stays LOW until the halt level is reached again.
- R6: With control bit 6 set, a halt field of 0, or a resume level equal to or above the halt level, keeps `rts_out` LOW.
- R7: With control bit 6 clear, `rts_out` follows modem-control bit 1 one cycle later.
- R8: With control bit 5 set, a strobed received byte equal to the match register (address 7) sets `spchar_flag` on the next edge. A mismatching byte, or any byte while bit 5 is clear, does not set it.
- R9: `spchar_flag` stays set until an `iir_rd` pulse clears it. A new match in the same cycle as the read keeps it set.
- R10: Every strobed byte appears on `fifo_we`/`fifo_wdata` one cycle later, whether or not it matched.
- R11: Register addresses are: 0 control, 1 trigger, 2 interrupt-enable, 3 FIFO-control, 4 modem-control, 5 divisor low, 6 divisor high, 7 match. While control bit 4 is 0, writes leave interrupt-enable bits [7:4], FIFO-control bits [5:4] and modem-control bits [7:5] unchanged and still update the other bits. While control bit 4 is 1, all bits are written.
- R12: While interrupt-enable bit 4 (sleep) is 1, writes to addresses 5 and 6 leave `div_q` unchanged. While it is 0, those writes update the low and high bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (map in R11) |
| reg_wdata | input | 8 | Register write data |
| iir_rd | input | 1 | Host read of interrupt-identification register |
| rx_level | input | 7 | Receive queue fill level, 0..64 |
| rx_strobe | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| cts_in | input | 1 | Asynchronous CTS line, HIGH = stop |
| tx_idle | input | 1 | Transmitter is between characters |
| rts_out | output | 1 | RTS line, HIGH = halt sender |
| tx_stop | output | 1 | Stop request to transmitter |
| spchar_flag | output | 1 | Match-character interrupt flag |
| fifo_we | output | 1 | Receive queue write enable |
| fifo_wdata | output | 8 | Receive queue write data |
| ctrl_q | output | 8 | Control register |
| trig_q | output | 8 | Trigger register |
| ier_q | output | 8 | Interrupt-enable register |
| fcr_q | output | 8 | FIFO-control register |
| mcr_q | output | 8 | Modem-control register |
| div_q | output | 16 | Baud divisor |

## Verification
The bench builds the unit with its defaults: a 64-deep queue, a trigger scale of four and a two-stage CTS synchronizer. These make every trigger level from 0 to 60 reachable. They also let the bench drive the queue completely full at 64, and they fix the CTS-to-stop latency at three edges. A table of fill levels walks RTS up through the halt level, holds it through the hysteresis band, and drops it at the resume level. It is followed by directed cases for invalid trigger pairs, character-boundary gating, flag clearing and the write locks.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_TRIG  = 3'd1,
    A_IER   = 3'd2,
    A_FCR   = 3'd3,
    A_MCR   = 3'd4,
    A_DIVLO = 3'd5,
    A_DIVHI = 3'd6,
    A_MATCH = 3'd7
  } reg_addr_e;

  // Bit positions the neighbouring logic decodes
  localparam int CTRL_CTS_EN = 7;
  localparam int CTRL_RTS_EN = 6;
  localparam int CTRL_SPC_EN = 5;
  localparam int CTRL_ENH_EN = 4;
  localparam int IER_SLEEP   = 4;
  localparam int MCR_RTS     = 1;

  localparam logic [7:0] IER_LOCK = 8'hF0;
  localparam logic [7:0] FCR_LOCK = 8'h30;
  localparam logic [7:0] MCR_LOCK = 8'hE0;
endpackage

// File: rtl/flowctl_regs.sv
module flowctl_regs
  import flowctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] trig_q,
  output logic [DATA_W-1:0] ier_q,
  output logic [DATA_W-1:0] fcr_q,
  output logic [DATA_W-1:0] mcr_q,
  output logic [DATA_W-1:0] match_q,
  output logic [DIV_W-1:0]  div_q
);
  reg_addr_e sel;
  logic      enh_ok;
  logic      div_ok;

  assign sel    = reg_addr_e'(addr);
  assign enh_ok = ctrl_q[CTRL_ENH_EN];
  assign div_ok = ~ier_q[IER_SLEEP];

  // Keep locked bits from the old value unless enhanced writes are open
  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [DATA_W-1:0] lock,
                                              input logic              open);
    return open ? new_v : ((old_v & lock) | (new_v & ~lock));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      trig_q  <= '0;
      ier_q   <= '0;
      fcr_q   <= '0;
      mcr_q   <= '0;
      match_q <= '0;
      div_q   <= '0;
    end else if (we) begin
      unique case (sel)
        A_CTRL:  ctrl_q  <= wdata;
        A_TRIG:  trig_q  <= wdata;
        A_IER:   ier_q   <= merge(ier_q, wdata, DATA_W'(IER_LOCK), enh_ok);
        A_FCR:   fcr_q   <= merge(fcr_q, wdata, DATA_W'(FCR_LOCK), enh_ok);
        A_MCR:   mcr_q   <= merge(mcr_q, wdata, DATA_W'(MCR_LOCK), enh_ok);
        A_DIVLO: if (div_ok) div_q[DATA_W-1:0]     <= wdata;
        A_DIVHI: if (div_ok) div_q[DIV_W-1:DATA_W] <= wdata;
        A_MATCH: match_q <= wdata;
        default: ;
      endcase
    end
  end

  p_enh_lock_r11: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CTRL_ENH_EN] |=> $stable(ier_q[7:4]) && $stable(fcr_q[5:4]) && $stable(mcr_q[7:5]));
  p_div_lock_r12: assert property (@(posedge clk) disable iff (rst)
    ier_q[IER_SLEEP] |=> $stable(div_q));
endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts #(
  parameter int LEVEL_W  = 7,
  parameter int TRIG_W   = 4,
  parameter int SCALE_SH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               manual,
  input  logic [TRIG_W-1:0]  halt_fld,
  input  logic [TRIG_W-1:0]  resume_fld,
  input  logic [LEVEL_W-1:0] level,
  output logic               rts_q
);
  localparam int SCALED_W = TRIG_W + SCALE_SH;

  logic [LEVEL_W-1:0] halt_lvl;
  logic [LEVEL_W-1:0] resume_lvl;
  logic               cfg_ok;

  assign halt_lvl   = LEVEL_W'({halt_fld,   {SCALE_SH{1'b0}}});
  assign resume_lvl = LEVEL_W'({resume_fld, {SCALE_SH{1'b0}}});
  assign cfg_ok     = (halt_fld != '0) && (resume_fld < halt_fld);

  always_ff @(posedge clk) begin
    if (rst)                     rts_q <= 1'b0;
    else if (!en)                rts_q <= manual;
    else if (!cfg_ok)            rts_q <= 1'b0;
    else if (level >= halt_lvl)  rts_q <= 1'b1;
    else if (level <= resume_lvl) rts_q <= 1'b0;
  end

  p_rts_halt_r4: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_ok && level >= halt_lvl) |=> rts_q);
  p_rts_band_r5: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && cfg_ok && level > resume_lvl && level < halt_lvl) |=> $stable(rts_q));
  p_rts_invalid_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !cfg_ok) |=> !rts_q);
  p_rts_manual_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (rts_q == $past(manual)));
endmodule

// File: rtl/flowctl_cts.sv
module flowctl_cts #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cts_in,
  input  logic tx_idle,
  output logic stop_q
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= cts_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], cts_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          stop_q <= 1'b0;
    else if (tx_idle) stop_q <= en & sync_q[SYNC_STAGES-1];
  end

  p_stop_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    !tx_idle |=> $stable(stop_q));
  p_stop_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && tx_idle) |=> !stop_q);
endmodule

// File: rtl/flowctl_spchar.sv
module flowctl_spchar #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] match_chr,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              clr,
  output logic              flag_q,
  output logic              we_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic hit;

  assign hit = en && rx_strobe && (rx_data == match_chr);

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q <= rx_strobe;
      if (rx_strobe) wdata_q <= rx_data;
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    (en && rx_strobe && rx_data == match_chr) |=> flag_q);
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  p_fwd_r10: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> we_q && wdata_q == $past(rx_data));
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import flowctl_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int DATA_W      = 8,
  parameter int TRIG_W      = 4,
  parameter int SCALE_SH    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1),
  localparam int DIV_W      = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               iir_rd,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic               rx_strobe,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               cts_in,
  input  logic               tx_idle,
  output logic               rts_out,
  output logic               tx_stop,
  output logic               spchar_flag,
  output logic               fifo_we,
  output logic [DATA_W-1:0]  fifo_wdata,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic [DATA_W-1:0]  trig_q,
  output logic [DATA_W-1:0]  ier_q,
  output logic [DATA_W-1:0]  fcr_q,
  output logic [DATA_W-1:0]  mcr_q,
  output logic [DIV_W-1:0]   div_q
);
  logic [DATA_W-1:0] match_q;

  flowctl_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .trig_q(trig_q), .ier_q(ier_q), .fcr_q(fcr_q),
    .mcr_q(mcr_q), .match_q(match_q), .div_q(div_q)
  );

  flowctl_rts #(.LEVEL_W(LEVEL_W), .TRIG_W(TRIG_W), .SCALE_SH(SCALE_SH)) u_rts (
    .clk(clk), .rst(rst), .en(ctrl_q[CTRL_RTS_EN]), .manual(mcr_q[MCR_RTS]),
    .halt_fld(trig_q[TRIG_W-1:0]), .resume_fld(trig_q[2*TRIG_W-1:TRIG_W]),
    .level(rx_level), .rts_q(rts_out)
  );

  flowctl_cts #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst(rst), .en(ctrl_q[CTRL_CTS_EN]), .cts_in(cts_in),
    .tx_idle(tx_idle), .stop_q(tx_stop)
  );

  flowctl_spchar #(.DATA_W(DATA_W)) u_spc (
    .clk(clk), .rst(rst), .en(ctrl_q[CTRL_SPC_EN]), .match_chr(match_q),
    .rx_strobe(rx_strobe), .rx_data(rx_data), .clr(iir_rd),
    .flag_q(spchar_flag), .we_q(fifo_we), .wdata_q(fifo_wdata)
  );

  p_level_range_r4: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LEVEL_W'(FIFO_DEPTH));
endmodule

// File: tb/uart_flow_ctl_test.sv
module uart_flow_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic iir_rd = 1'b0;
  logic [6:0] rx_level = '0;
  logic rx_strobe = 1'b0;
  logic [7:0] rx_data = '0;
  logic cts_in = 1'b0;
  logic tx_idle = 1'b1;
  logic rts_out, tx_stop, spchar_flag, fifo_we;
  logic [7:0] fifo_wdata, ctrl_q, trig_q, ier_q, fcr_q, mcr_q;
  logic [15:0] div_q;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_flow_ctl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .iir_rd(iir_rd), .rx_level(rx_level), .rx_strobe(rx_strobe), .rx_data(rx_data),
    .cts_in(cts_in), .tx_idle(tx_idle), .rts_out(rts_out), .tx_stop(tx_stop),
    .spchar_flag(spchar_flag), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .ctrl_q(ctrl_q), .trig_q(trig_q), .ier_q(ier_q), .fcr_q(fcr_q), .mcr_q(mcr_q),
    .div_q(div_q)
  );

  // {expected rts, level[6:0]}; halt 32, resume 16
  localparam bit [7:0] RTS_VEC [0:12] = '{
    8'h00, 8'h14, 8'h1F, 8'hA0, 8'hA8, 8'h94, 8'h91,
    8'h10, 8'h0A, 8'h19, 8'hBC, 8'hC0, 8'h00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 ctrl", ctrl_q, 0);  chk("R1 div", div_q, 0);
    chk("R1 rts", rts_out, 0);  chk("R1 stop", tx_stop, 0);
    chk("R1 flag", spchar_flag, 0); chk("R1 fifo_we", fifo_we, 0);

    // R4/R5 table walk
    wr(3'd1, 8'h48);
    wr(3'd0, 8'h40);
    foreach (RTS_VEC[i]) begin
      rx_level = RTS_VEC[i][6:0];
      @(negedge clk);
      chk($sformatf("R4/R5 step %0d", i), rts_out, RTS_VEC[i][7]);
    end

    // R6 invalid configs
    rx_level = 7'd40;
    wr(3'd1, 8'h88); idle(1);
    chk("R6 resume==halt", rts_out, 0);
    wr(3'd1, 8'h40); idle(1);
    chk("R6 halt zero", rts_out, 0);
    rx_level = 7'd0;

    // R7 manual mode
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h02); idle(1);
    chk("R7 manual high", rts_out, 1);
    wr(3'd4, 8'h00); idle(1);
    chk("R7 manual low", rts_out, 0);

    // R2/R3 CTS
    wr(3'd0, 8'h80);
    cts_in = 1'b1;
    idle(2);
    chk("R2 not yet", tx_stop, 0);
    idle(1);
    chk("R2 stop", tx_stop, 1);
    tx_idle = 1'b0; cts_in = 1'b0;
    idle(5);
    chk("R3 held mid-char", tx_stop, 1);
    tx_idle = 1'b1;
    idle(1);
    chk("R3 release at boundary", tx_stop, 0);
    wr(3'd0, 8'h00);
    cts_in = 1'b1;
    idle(4);
    chk("R2 ignored when off", tx_stop, 0);
    cts_in = 1'b0;

    // R8/R9/R10 match character
    wr(3'd7, 8'h13);
    wr(3'd0, 8'h20);
    @(negedge clk); rx_strobe = 1'b1; rx_data = 8'h13;
    @(negedge clk); rx_strobe = 1'b0;
    chk("R8 hit", spchar_flag, 1);
    chk("R10 we", fifo_we, 1); chk("R10 data", fifo_wdata, 8'h13);
    idle(3);
    chk("R9 sticky", spchar_flag, 1);
    iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0;
    chk("R9 cleared", spchar_flag, 0);
    rx_strobe = 1'b1; rx_data = 8'h14; @(negedge clk); rx_strobe = 1'b0;
    chk("R8 miss", spchar_flag, 0); chk("R10 miss data", fifo_wdata, 8'h14);
    rx_strobe = 1'b1; rx_data = 8'h13; iir_rd = 1'b1;
    @(negedge clk); rx_strobe = 1'b0; iir_rd = 1'b0;
    chk("R9 set beats clear", spchar_flag, 1);
    iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0;
    wr(3'd0, 8'h00);
    rx_strobe = 1'b1; rx_data = 8'h13; @(negedge clk); rx_strobe = 1'b0;
    chk("R8 disabled", spchar_flag, 0); chk("R10 disabled we", fifo_we, 1);

    // R11 enhanced-field lock
    wr(3'd2, 8'hF5); chk("R11 ier locked", ier_q, 8'h05);
    wr(3'd3, 8'h37); chk("R11 fcr locked", fcr_q, 8'h07);
    wr(3'd4, 8'hE2); chk("R11 mcr locked", mcr_q, 8'h02);
    wr(3'd0, 8'h10);
    wr(3'd2, 8'hA5); chk("R11 ier open", ier_q, 8'hA5);
    wr(3'd3, 8'h37); chk("R11 fcr open", fcr_q, 8'h37);
    wr(3'd4, 8'hE0); chk("R11 mcr open", mcr_q, 8'hE0);

    // R12 divisor lock
    wr(3'd5, 8'h34); wr(3'd6, 8'h12);
    chk("R12 div written", div_q, 16'h1234);
    wr(3'd2, 8'h10);
    wr(3'd5, 8'h99); wr(3'd6, 8'h77);
    chk("R12 div locked", div_q, 16'h1234);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h99);
    chk("R12 div unlocked", div_q, 16'h1299);

    done = 1'b1;
    finish_run();
  end
endmodule